// File: doc/BRIEF.md
# Two-hot opcode field decoder

This block turns an opcode field into per-operation enables for one pipeline stage. The field is not a binary number. Each operation owns one unordered pair of bit positions, and it is selected when exactly those two bits are set. Decoding a legal field therefore takes one two-input AND per operation, plus a check that exactly two bits are set. That check is small enough to repeat in every stage that needs its own control lines.

Fields that are not exactly two-hot are sorted into two classes. A field with no bits set, or with a single bit set, decodes as a no-operation. A field with three or more bits set, such as random data fetched as an instruction, raises an illegal flag. In both cases every operation enable stays low.

Results are registered at the clock edge where the valid strobe is high. A low strobe clears all outputs at the next edge. A parameter selects how the set bits are counted: a saturating ripple chain or an adder. The choice changes only the structure of the logic, never the outputs.

Top module: `pair_opcode_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are zero after that edge, whatever the field and strobe are.
- R2: With the strobe high and exactly two bits set at positions lo < hi, the next edge raises only `op_en_o` bit lo*W - lo*(lo+1)/2 + (hi-lo-1), where W is the field width. For W = 8, pair (0,1) is bit 0, (0,7) is bit 6, (1,2) is bit 7 and (6,7) is bit 27. `nop_o` and `illegal_o` stay low.
- R3: With the strobe high and zero or one bit set, the next edge sets `nop_o` to 1 and holds `illegal_o` and every enable at 0.
- R4: With the strobe high and three or more bits set, the next edge sets `illegal_o` to 1 and holds `nop_o` and every enable at 0.
- R5: With the strobe low, the next edge clears every enable, `nop_o` and `illegal_o`, even if the field holds a legal pair.
- R6: At most one enable is ever high, and at most one of {any enable, `nop_o`, `illegal_o`} is high at any time.
- R7: The adder counting variant and the ripple counting variant give identical outputs for every field and strobe value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| field_valid_i | input | 1 | Strobe: the field is sampled at this edge |
| field_i | input | FIELD_W (8) | Two-hot opcode field |
| op_en_o | output | FIELD_W*(FIELD_W-1)/2 (28) | Registered one-hot operation enables, one per bit pair |
| nop_o | output | 1 | Registered flag: the field had fewer than two bits set |
| illegal_o | output | 1 | Registered flag: the field had more than two bits set |

## Verification
The bench sweeps all 28 legal pairs and checks each against a slot number it computes itself. A slot formula that is off by one, or a pair order that is transposed, would show up as the wrong enable bit. It applies the empty field and every single-bit field, and several dense fields including the all-ones byte. A classifier whose threshold is off by one would then raise the wrong flag, or let a pair enable leak through for a three-bit field. It presents legal fields with the strobe low and under reset. A design that ignored either would register an enable. Finally, an exhaustive sweep over all 256 fields compares both counting variants with the model, so that the two variants cannot drift apart.

// File: rtl/pair_opcode_pkg.sv
package pair_opcode_pkg;

   // Classification of a field by the number of set bits
   typedef enum logic [1:0] {
      FC_SPARSE = 2'd0,   // fewer than two bits: no-operation
      FC_PAIR   = 2'd1,   // exactly two bits: legal operation
      FC_EXCESS = 2'd2    // more than two bits: illegal
   } field_class_e;

   // Counting structure variants
   localparam int CNT_RIPPLE = 0;
   localparam int CNT_ADDER  = 1;

   // Number of unordered bit pairs in a field of the given width
   function automatic int pair_total(input int width);
      return (width * (width - 1)) / 2;
   endfunction

   // Slot of pair (lo, hi), lo < hi, enumerated by lo then hi
   function automatic int pair_slot(input int lo, input int hi, input int width);
      return lo * width - (lo * (lo + 1)) / 2 + (hi - lo - 1);
   endfunction

endpackage

// File: rtl/pair_opcode_class.sv
module pair_opcode_class
   import pair_opcode_pkg::*;
#(
   parameter int FIELD_W     = 8,
   parameter int COUNT_STYLE = CNT_RIPPLE
) (
   input  logic [FIELD_W-1:0] field_i,
   output field_class_e       class_o
);

   logic at_least2;
   logic at_least3;

   generate
      if (COUNT_STYLE == CNT_RIPPLE) begin : g_ripple
         // Saturating thermometer: ge1/ge2/ge3 after bits [k-1:0]
         logic [FIELD_W-1:0] ge1;
         logic [FIELD_W:0]   ge2;
         logic [FIELD_W:0]   ge3;

         assign ge1[0] = 1'b0;
         assign ge2[0] = 1'b0;
         assign ge3[0] = 1'b0;

         for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
            if (k < FIELD_W - 1) begin : g_ge1
               assign ge1[k+1] = ge1[k] | field_i[k];
            end
            assign ge2[k+1] = ge2[k] | (ge1[k] & field_i[k]);
            assign ge3[k+1] = ge3[k] | (ge2[k] & field_i[k]);
         end

         assign at_least2 = ge2[FIELD_W];
         assign at_least3 = ge3[FIELD_W];
      end else if (COUNT_STYLE == CNT_ADDER) begin : g_adder
         localparam int CW = $clog2(FIELD_W + 1);
         logic [CW-1:0] ones;

         always_comb begin
            ones = '0;
            for (int k = 0; k < FIELD_W; k++) begin
               ones = ones + CW'(field_i[k]);
            end
         end

         assign at_least2 = (ones >= CW'(2));
         assign at_least3 = (ones >= CW'(3));
      end else begin : g_bad_style
         $error("pair_opcode_class: unknown COUNT_STYLE");
      end
   endgenerate

   always_comb begin
      if (at_least3) begin
         class_o = FC_EXCESS;
      end else if (at_least2) begin
         class_o = FC_PAIR;
      end else begin
         class_o = FC_SPARSE;
      end
   end

endmodule

// File: rtl/pair_opcode_matrix.sv
module pair_opcode_matrix
   import pair_opcode_pkg::*;
#(
   parameter int FIELD_W = 8
) (
   input  logic [FIELD_W-1:0]                 field_i,
   input  logic                               pair_ok_i,
   output logic [pair_total(FIELD_W)-1:0]     en_o
);

   // One AND gate per unordered pair, gated by the exactly-two condition
   generate
      for (genvar lo = 0; lo < FIELD_W - 1; lo++) begin : g_lo
         for (genvar hi = lo + 1; hi < FIELD_W; hi++) begin : g_hi
            localparam int SLOT = pair_slot(lo, hi, FIELD_W);
            assign en_o[SLOT] = pair_ok_i & field_i[lo] & field_i[hi];
         end
      end
   endgenerate

endmodule

// File: rtl/pair_opcode_stage.sv
module pair_opcode_stage #(
   parameter int W = 30
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   // Loads on strobe; clears on reset or when the strobe is low
   always_ff @(posedge clk) begin
      if (rst || !load_i) begin
         q_o <= '0;
      end else begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/pair_opcode_decoder.sv
module pair_opcode_decoder
   import pair_opcode_pkg::*;
#(
   parameter int FIELD_W     = 8,
   parameter int COUNT_STYLE = CNT_RIPPLE
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                field_valid_i,
   input  logic [FIELD_W-1:0]                  field_i,
   output logic [(FIELD_W*(FIELD_W-1))/2-1:0]  op_en_o,
   output logic                                nop_o,
   output logic                                illegal_o
);

   localparam int NUM_OPS = pair_total(FIELD_W);
   localparam int STAGE_W = NUM_OPS + 2;

   generate
      if (FIELD_W < 2) begin : g_chk_narrow
         $error("pair_opcode_decoder: FIELD_W must be at least 2");
      end
      if (FIELD_W > 16) begin : g_chk_wide
         $error("pair_opcode_decoder: FIELD_W above 16 is not supported");
      end
      if ((COUNT_STYLE != CNT_RIPPLE) && (COUNT_STYLE != CNT_ADDER)) begin : g_chk_style
         $error("pair_opcode_decoder: COUNT_STYLE out of range");
      end
   endgenerate

   field_class_e         fclass;
   logic                 pair_ok;
   logic [NUM_OPS-1:0]   en_comb;
   logic [STAGE_W-1:0]   stage_d;
   logic [STAGE_W-1:0]   stage_q;

   pair_opcode_class #(
      .FIELD_W     (FIELD_W),
      .COUNT_STYLE (COUNT_STYLE)
   ) class_i (
      .field_i (field_i),
      .class_o (fclass)
   );

   assign pair_ok = (fclass == FC_PAIR);

   pair_opcode_matrix #(
      .FIELD_W (FIELD_W)
   ) matrix_i (
      .field_i   (field_i),
      .pair_ok_i (pair_ok),
      .en_o      (en_comb)
   );

   assign stage_d = {en_comb, (fclass == FC_SPARSE), (fclass == FC_EXCESS)};

   pair_opcode_stage #(
      .W (STAGE_W)
   ) stage_i (
      .clk    (clk),
      .rst    (rst),
      .load_i (field_valid_i),
      .d_i    (stage_d),
      .q_o    (stage_q)
   );

   assign op_en_o   = stage_q[STAGE_W-1:2];
   assign nop_o     = stage_q[1];
   assign illegal_o = stage_q[0];

endmodule

// File: rtl/pair_opcode_decoder_chk.sv
module pair_opcode_decoder_chk
   import pair_opcode_pkg::*;
#(
   parameter int FIELD_W = 8
) (
   input logic                                clk,
   input logic                                rst,
   input logic                                field_valid_i,
   input logic [FIELD_W-1:0]                  field_i,
   input logic [(FIELD_W*(FIELD_W-1))/2-1:0]  op_en_o,
   input logic                                nop_o,
   input logic                                illegal_o
);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (op_en_o == '0 && !nop_o && !illegal_o)); // R1

   AST_PAIR_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (field_valid_i && $countones(field_i) == 2) |=>
      ($countones(op_en_o) == 1 && !nop_o && !illegal_o)); // R2

   generate
      for (genvar lo = 0; lo < FIELD_W - 1; lo++) begin : g_lo
         for (genvar hi = lo + 1; hi < FIELD_W; hi++) begin : g_hi
            localparam int SLOT = pair_slot(lo, hi, FIELD_W);
            AST_SLOT_MATCH: assert property (@(posedge clk) disable iff (rst)
               op_en_o[SLOT] |-> $past(field_i[lo] && field_i[hi] && field_valid_i)); // R2
         end
      end
   endgenerate

   AST_SPARSE_NOP: assert property (@(posedge clk) disable iff (rst)
      (field_valid_i && $countones(field_i) < 2) |=>
      (nop_o && op_en_o == '0 && !illegal_o)); // R3

   AST_EXCESS_FLAG: assert property (@(posedge clk) disable iff (rst)
      (field_valid_i && $countones(field_i) > 2) |=>
      (illegal_o && op_en_o == '0 && !nop_o)); // R4

   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      !field_valid_i |=> (op_en_o == '0 && !nop_o && !illegal_o)); // R5

   AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(op_en_o)); // R6

   AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
      $countones({|op_en_o, nop_o, illegal_o}) <= 1); // R6

endmodule

bind pair_opcode_decoder pair_opcode_decoder_chk #(
   .FIELD_W (FIELD_W)
) chk_i (
   .clk           (clk),
   .rst           (rst),
   .field_valid_i (field_valid_i),
   .field_i       (field_i),
   .op_en_o       (op_en_o),
   .nop_o         (nop_o),
   .illegal_o     (illegal_o)
);

// File: tb/pair_opcode_decoder_tb.sv
module pair_opcode_decoder_tb_top;

   localparam int W    = 8;
   localparam int NOPS = 28;
   localparam int PW   = NOPS + 2;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            vld = 1'b0;
   logic [W-1:0]    fld = '0;
   logic [NOPS-1:0] en_a, en_b;
   logic            nop_a, nop_b, ill_a, ill_b;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   pair_opcode_decoder #(.FIELD_W(W), .COUNT_STYLE(0)) dut_i (
      .clk(clk), .rst(rst), .field_valid_i(vld), .field_i(fld),
      .op_en_o(en_a), .nop_o(nop_a), .illegal_o(ill_a));

   pair_opcode_decoder #(.FIELD_W(W), .COUNT_STYLE(1)) dut_adder_i (
      .clk(clk), .rst(rst), .field_valid_i(vld), .field_i(fld),
      .op_en_o(en_b), .nop_o(nop_b), .illegal_o(ill_b));

   // Slot number of pair (lo, hi) as stated in R2
   function automatic int bench_slot(input int lo, input int hi);
      return lo * W - (lo * (lo + 1)) / 2 + (hi - lo - 1);
   endfunction

   // Expected {enables, nop, illegal} from the requirements
   function automatic logic [PW-1:0] model(input logic r, input logic v, input logic [W-1:0] f);
      logic [NOPS-1:0] e;
      int cnt, lo, hi;
      e = '0; cnt = 0; lo = -1; hi = -1;
      if (r || !v) return '0;
      for (int k = 0; k < W; k++) begin
         if (f[k]) begin
            cnt++;
            if (lo < 0) lo = k; else if (hi < 0) hi = k;
         end
      end
      if (cnt < 2) return {e, 1'b1, 1'b0};
      if (cnt > 2) return {e, 1'b0, 1'b1};
      e[bench_slot(lo, hi)] = 1'b1;
      return {e, 1'b0, 1'b0};
   endfunction

   task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: field=%h got=%h expected=%h", req, fld, got, exp);
      end
   endtask

   // Drive away from the edge, sample 1 ns after the edge that registers it
   task automatic apply_and_check(input string req, input logic r, input logic v, input logic [W-1:0] f);
      @(negedge clk);
      rst = r; vld = v; fld = f;
      @(posedge clk);
      #1;
      check(req, {en_a, nop_a, ill_a}, model(r, v, f));
      check({req, "/R7"}, {en_b, nop_b, ill_b}, {en_a, nop_a, ill_a});
   endtask

   task automatic t_reset;
      apply_and_check("R1 reset with legal pair", 1'b1, 1'b1, 8'h03);
      apply_and_check("R1 reset with dense field", 1'b1, 1'b1, 8'hFF);
      apply_and_check("R2 pair before reset", 1'b0, 1'b1, 8'h81);
      apply_and_check("R1 mid-run reset", 1'b1, 1'b1, 8'h81);
   endtask

   task automatic t_pairs;
      for (int lo = 0; lo < W - 1; lo++) begin
         for (int hi = lo + 1; hi < W; hi++) begin
            logic [W-1:0] f;
            f = '0; f[lo] = 1'b1; f[hi] = 1'b1;
            apply_and_check("R2 pair slot", 1'b0, 1'b1, f);
         end
      end
      // Fixed anchors stated in R2
      apply_and_check("R2 anchor (6,7)", 1'b0, 1'b1, 8'hC0);
      check("R2 anchor (6,7)=bit27", {31'd0, en_a[27]}, 32'd1);
      apply_and_check("R2 anchor (1,2)", 1'b0, 1'b1, 8'h06);
      check("R2 anchor (1,2)=bit7", {31'd0, en_a[7]}, 32'd1);
   endtask

   task automatic t_sparse;
      apply_and_check("R3 empty field", 1'b0, 1'b1, 8'h00);
      for (int k = 0; k < W; k++) begin
         apply_and_check("R3 single bit", 1'b0, 1'b1, 8'(1 << k));
      end
   endtask

   task automatic t_excess;
      apply_and_check("R4 three low bits", 1'b0, 1'b1, 8'h07);
      apply_and_check("R4 three high bits", 1'b0, 1'b1, 8'hE0);
      apply_and_check("R4 scattered three", 1'b0, 1'b1, 8'h91);
      apply_and_check("R4 alternating", 1'b0, 1'b1, 8'h55);
      apply_and_check("R4 all ones", 1'b0, 1'b1, 8'hFF);
   endtask

   task automatic t_idle;
      apply_and_check("R5 legal pair loaded", 1'b0, 1'b1, 8'h03);
      apply_and_check("R5 strobe low with pair", 1'b0, 1'b0, 8'h03);
      apply_and_check("R5 strobe low with empty", 1'b0, 1'b0, 8'h00);
      apply_and_check("R5 strobe low with dense", 1'b0, 1'b0, 8'hFF);
   endtask

   task automatic t_sweep;
      for (int f = 0; f < 256; f++) begin
         apply_and_check("R6 sweep", 1'b0, 1'b1, 8'(f));
         check("R6 one class", {30'd0, 2'($countones({|en_a, nop_a, ill_a}))}, 32'd1);
      end
   endtask

   initial begin
      t_reset();
      t_pairs();
      t_sparse();
      t_excess();
      t_idle();
      t_sweep();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule